// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Coprocessor

This block takes a small microcontroller's compression work off its hands. The processor sees it as four byte-wide registers. Software writes the 64 pixels of one 8x8 block, one signed byte per write. It then writes a start command and polls a status byte until the block reports that it is idle again. After that it reads back 64 signed 16-bit coefficients, each as a high byte followed by a low byte.

The transform runs in scaled integer arithmetic. An internal 8x8 table of signed cosine constants has six fractional bits, so 64 stands for 1.0. Every product is shifted right arithmetically by six before it is accumulated. One signed multiplier and two accumulators are shared over a nested loop. The loop counters are u (output row), v (output column), x (input row) and j (input column).

The controller has four states. `S_IDLE` waits for a start command. `S_ROWMAC` runs eight cycles over j, building the partial sum for one input row. `S_COLMAC` takes one cycle to fold that partial sum into the coefficient accumulator. `S_SCALE` takes one cycle to normalise and store the coefficient.

The transitions are:
- idle-to-row on a start command.
- row-to-row while j is below 7.
- row-to-col when j is 7.
- col-to-row while x is below 7.
- col-to-scale when x is 7.
- scale-to-row while coefficients remain.
- scale-to-idle after coefficient (7,7).

Top module: `dct_copro`

## Requirements
- R1: The register offsets are: 0 status, 1 command, 2 result pop, 3 pixel push. Reading offset 1 or offset 3 returns 0x00.
- R2: Each write to offset 3 stores the signed 8-bit pixel as a 16-bit value, sign-extended and shifted left by 6. The value goes to row index/8, column index%8 of the input block, and the push index then increments.
- R3: When the push index already equals 64 at a pixel write, it wraps to 0 before the store. A 65th pixel therefore replaces pixel (0,0). The index never exceeds 64.
- R4: Writing 0x01 to offset 1 while idle starts a transform, and any other command value has no effect. Status (offset 0) reads 0x01 while busy and 0x00 when idle.
- R5: For each coefficient (u,v), the block first forms, for each row x, s[x] = sum over j of (in[x][j]·cos[j][v]) >>> 6. It then forms r = sum over x of (s[x]·cos[x][u]) >>> 6, using 32-bit accumulators. The cosine rows are:
  - row 0: 64 62 59 53 45 35 24 12
  - row 1: 64 53 24 -12 -45 -62 -59 -35
  - row 2: 64 35 -24 -62 -45 12 59 53
  - row 3: 64 12 -59 -35 45 53 -24 -62
  - row 4: 64 -12 -59 35 45 -53 -24 62
  - row 5: 64 -35 -24 62 -45 -12 59 -53
  - row 6: 64 -53 24 12 -45 62 -59 35
  - row 7: 64 -62 59 -53 45 -35 24 -12
- R6: The factor C(k) is 64 for k not 0 and 5 for k = 0. The block forms K = ((((16·C(u)) >> 6)·C(v)) >> 6). The stored coefficient is the low 16 bits of ((r·K) >>> 6) >>> 6. With these constants K is 0 at (0,0), so that coefficient is always 0.
- R7: Two consecutive reads of offset 2 return one coefficient, high byte then low byte. Coefficients come out in row-major order (index u·8+v). The read pointer returns to coefficient 0 on every start.
- R8: Status reads 0x01 for exactly 4672 consecutive cycles after the start write: 64 coefficients times (8·9+1) cycles.
- R9: When a transform completes, the push index returns to 0, so the next pixel goes to (0,0).
- R10: Pixel writes and start commands issued while busy change neither the input block nor the running transform.
- R11: A synchronous active-high reset leaves the block idle, with the push index and the read pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; pops a byte at offset 2 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from offset and state |

## Verification
Read data is combinational, so each read is sampled in the same cycle its strobe is driven, ahead of the edge that advances the pop pointer. Status is expected at 0x01 on the first read after the start edge. The bench counts every polled cycle and expects exactly 4672 busy readings followed by an idle one. Coefficients are compared only after status has gone idle, against a model of the stated arithmetic. The ignored-write and partial-readout cases are judged by the coefficients read afterwards, so any disturbance of the input block or the pointers shows up at the read port.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
package dct_pkg;

    localparam int BLK_N    = 8;
    localparam int IDX_W    = $clog2(BLK_N);
    localparam int COS_W    = 8;
    localparam int COEF_W   = 16;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ROWMAC,
        S_COLMAC,
        S_SCALE
    } dct_state_t;

    // Signed cosine constants, 6 fractional bits; first column at the MSB end
    function automatic logic signed [COS_W-1:0] cos_coef(
        input logic [IDX_W-1:0] row,
        input logic [IDX_W-1:0] col
    );
        logic [BLK_N*COS_W-1:0] line;
        unique case (row)
            3'd0: line = 64'h40_3E_3B_35_2D_23_18_0C;
            3'd1: line = 64'h40_35_18_F4_D3_C2_C5_DD;
            3'd2: line = 64'h40_23_E8_C2_D3_0C_3B_35;
            3'd3: line = 64'h40_0C_C5_DD_2D_35_E8_C2;
            3'd4: line = 64'h40_F4_C5_23_2D_CB_E8_3E;
            3'd5: line = 64'h40_DD_E8_3E_D3_F4_3B_CB;
            3'd6: line = 64'h40_CB_18_0C_D3_3E_C5_23;
            default: line = 64'h40_C2_3B_CB_2D_DD_18_F4;
        endcase
        return line[COS_W*(BLK_N-1-int'(col)) +: COS_W];
    endfunction

    function automatic int norm_c(input logic [IDX_W-1:0] k);
        return (k != '0) ? 64 : 5;
    endfunction

    // Combined scale constant applied to the coefficient accumulator
    function automatic logic signed [COS_W-1:0] scale_k(
        input logic [IDX_W-1:0] u,
        input logic [IDX_W-1:0] v
    );
        int t;
        t = (((16 * norm_c(u)) >> 6) * norm_c(v)) >> 6;
        return COS_W'(t);
    endfunction

endpackage

// File: rtl/dct_seq.sv
`timescale 1ns/1ps
module dct_seq
    import dct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output dct_state_t       state,
    output logic [IDX_W-1:0] j_idx,
    output logic [IDX_W-1:0] x_idx,
    output logic [IDX_W-1:0] u_idx,
    output logic [IDX_W-1:0] v_idx,
    output logic             last_coef
);

    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(BLK_N - 1);

    dct_state_t state_nx;

    assign last_coef = (u_idx == IDX_MAX) && (v_idx == IDX_MAX);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_ROWMAC;
            S_ROWMAC: if (j_idx == IDX_MAX) state_nx = S_COLMAC;
            S_COLMAC: state_nx = (x_idx == IDX_MAX) ? S_SCALE : S_ROWMAC;
            S_SCALE:  state_nx = last_coef ? S_IDLE : S_ROWMAC;
            default:  state_nx = S_IDLE;
        endcase
    end

    // Loop counters
    always_ff @(posedge clk) begin
        if (rst) begin
            j_idx <= '0;
            x_idx <= '0;
            u_idx <= '0;
            v_idx <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    j_idx <= '0;
                    x_idx <= '0;
                    u_idx <= '0;
                    v_idx <= '0;
                end
                S_ROWMAC: j_idx <= j_idx + 1'b1;
                S_COLMAC: if (x_idx != IDX_MAX) x_idx <= x_idx + 1'b1;
                S_SCALE: begin
                    x_idx <= '0;
                    v_idx <= v_idx + 1'b1;
                    if (v_idx == IDX_MAX) u_idx <= u_idx + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R8: a row pass always lasts eight cycles before the column step
    a_r8_row_length: assert property (@(posedge clk) disable iff (rst)
        (state == S_ROWMAC && j_idx != IDX_MAX) |=> (state == S_ROWMAC));

    // R8: the column step is only ever reached from the last row cycle
    a_r8_col_after_row: assert property (@(posedge clk) disable iff (rst)
        (state == S_COLMAC) |-> ($past(state) == S_ROWMAC && $past(j_idx) == IDX_MAX));

    // R8: scaling is followed by a new row pass or by idle
    a_r8_scale_exit: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCALE) |=> (state == S_ROWMAC || state == S_IDLE));

endmodule

// File: rtl/dct_mac.sv
`timescale 1ns/1ps
module dct_mac
    import dct_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FRAC_BITS = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  dct_state_t               state,
    input  logic [IDX_W-1:0]         j_idx,
    input  logic [IDX_W-1:0]         x_idx,
    input  logic signed [COEF_W-1:0] pix,
    input  logic signed [COS_W-1:0]  cos_row,
    input  logic signed [COS_W-1:0]  cos_col,
    input  logic signed [COS_W-1:0]  k_val,
    output logic signed [COEF_W-1:0] result
);

    localparam int PROD_W = ACC_W + COS_W;

    logic signed [ACC_W-1:0]  s_acc;
    logic signed [ACC_W-1:0]  r_acc;
    logic signed [ACC_W-1:0]  op_a;
    logic signed [COS_W-1:0]  op_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_sh;

    // Operand selection for the shared multiplier
    always_comb begin
        op_a = '0;
        op_b = '0;
        unique case (state)
            S_ROWMAC: begin
                op_a = {{(ACC_W-COEF_W){pix[COEF_W-1]}}, pix};
                op_b = cos_row;
            end
            S_COLMAC: begin
                op_a = s_acc;
                op_b = cos_col;
            end
            S_SCALE: begin
                op_a = r_acc;
                op_b = k_val;
            end
            default: ;
        endcase
    end

    assign prod    = PROD_W'(op_a) * PROD_W'(op_b);
    assign prod_sh = ACC_W'(prod >>> FRAC_BITS);
    assign result  = COEF_W'(prod >>> (2 * FRAC_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            s_acc <= '0;
            r_acc <= '0;
        end else begin
            if (state == S_ROWMAC)
                s_acc <= ((j_idx == '0) ? '0 : s_acc) + prod_sh;
            if (state == S_COLMAC)
                r_acc <= ((x_idx == '0) ? '0 : r_acc) + prod_sh;
        end
    end

    // R5: the row partial sum restarts on the first column of every row pass
    a_r5_row_restart: assert property (@(posedge clk) disable iff (rst)
        (state == S_ROWMAC && j_idx == '0) |=> (s_acc == $past(prod_sh)));

endmodule

// File: rtl/dct_copro.sv
`timescale 1ns/1ps
module dct_copro
    import dct_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int FRAC_BITS = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int BLK_SZ = BLK_N * BLK_N;
    localparam int PTR_W  = $clog2(BLK_SZ);
    localparam int PUSH_W = PTR_W + 1;
    localparam logic [1:0] OFS_STATUS = 2'd0;
    localparam logic [1:0] OFS_CMD    = 2'd1;
    localparam logic [1:0] OFS_POP    = 2'd2;
    localparam logic [1:0] OFS_PUSH   = 2'd3;
    localparam logic [PUSH_W-1:0] PUSH_FULL = PUSH_W'(BLK_SZ);

    dct_state_t              state;
    logic [IDX_W-1:0]        j_idx, x_idx, u_idx, v_idx;
    logic                    last_coef;
    logic                    busy;
    logic                    start_cmd;
    logic                    push_wr;
    logic                    pop_rd;
    logic                    finish;
    logic [PUSH_W-1:0]       push_idx;
    logic [PTR_W-1:0]        push_slot;
    logic [PTR_W-1:0]        rd_ptr;
    logic                    rd_lo;
    logic signed [COEF_W-1:0] in_buf  [BLK_SZ];
    logic signed [COEF_W-1:0] out_buf [BLK_SZ];
    logic signed [COEF_W-1:0] pix;
    logic signed [COEF_W-1:0] coef;
    logic signed [COS_W-1:0]  cos_row, cos_col, k_val;
    logic [COEF_W-1:0]        pop_word;

    assign busy      = (state != S_IDLE);
    assign start_cmd = bus_wr && (bus_addr == OFS_CMD) && (bus_wdata == 8'd1) && !busy;
    assign push_wr   = bus_wr && (bus_addr == OFS_PUSH) && !busy;
    assign pop_rd    = bus_rd && (bus_addr == OFS_POP);
    assign finish    = (state == S_SCALE) && last_coef;
    assign push_slot = (push_idx == PUSH_FULL) ? '0 : push_idx[PTR_W-1:0];

    dct_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_cmd),
        .state     (state),
        .j_idx     (j_idx),
        .x_idx     (x_idx),
        .u_idx     (u_idx),
        .v_idx     (v_idx),
        .last_coef (last_coef)
    );

    assign pix     = in_buf[{x_idx, j_idx}];
    assign cos_row = cos_coef(j_idx, v_idx);
    assign cos_col = cos_coef(x_idx, u_idx);
    assign k_val   = scale_k(u_idx, v_idx);

    dct_mac #(
        .ACC_W     (ACC_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .j_idx   (j_idx),
        .x_idx   (x_idx),
        .pix     (pix),
        .cos_row (cos_row),
        .cos_col (cos_col),
        .k_val   (k_val),
        .result  (coef)
    );

    // Push index
    always_ff @(posedge clk) begin
        if (rst)          push_idx <= '0;
        else if (finish)  push_idx <= '0;
        else if (push_wr) push_idx <= PUSH_W'(push_slot) + 1'b1;
    end

    // Input block storage
    always_ff @(posedge clk) begin
        if (push_wr)
            in_buf[push_slot] <= {{(COEF_W-8-FRAC_BITS){bus_wdata[7]}}, bus_wdata, {FRAC_BITS{1'b0}}};
    end

    // Output block storage
    always_ff @(posedge clk) begin
        if (state == S_SCALE)
            out_buf[{u_idx, v_idx}] <= coef;
    end

    // Pop pointer: one coefficient per pair of reads
    always_ff @(posedge clk) begin
        if (rst || start_cmd) begin
            rd_ptr <= '0;
            rd_lo  <= 1'b0;
        end else if (pop_rd) begin
            rd_lo <= !rd_lo;
            if (rd_lo) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign pop_word = out_buf[rd_ptr];

    always_comb begin
        unique case (bus_addr)
            OFS_STATUS: bus_rdata = {7'd0, busy};
            OFS_POP:    bus_rdata = rd_lo ? pop_word[7:0] : pop_word[15:8];
            default:    bus_rdata = 8'd0;
        endcase
    end

    // R4: an accepted start command makes the block busy on the next cycle
    a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> busy);

    // R7: start returns the pop pointer to the first high byte
    a_r7_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> (rd_ptr == '0 && !rd_lo));

    // R3: the push index never passes the block size
    a_r3_idx_bound: assert property (@(posedge clk) disable iff (rst)
        push_idx <= PUSH_FULL);

    // R10 / R9: while busy the index holds, except for the clear at completion
    a_r10_push_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> (push_idx == $past(push_idx) || push_idx == '0));

    // R6: the (0,0) coefficient is stored as zero
    a_r6_dc_zero: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCALE && u_idx == '0 && v_idx == '0) |=> (out_buf[0] == '0));

    // R11: reset leaves the block idle with both pointers cleared
    a_r11_reset_state: assert property (@(posedge clk)
        rst |=> (!busy && push_idx == '0 && rd_ptr == '0 && !rd_lo));

endmodule

// File: tb/tb_dct_copro.sv
`timescale 1ns/1ps
module tb_dct_copro;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic       bus_rd;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    int pix [64];

    const int COS_T [64] = '{
        64, 62, 59, 53, 45, 35, 24, 12,
        64, 53, 24,-12,-45,-62,-59,-35,
        64, 35,-24,-62,-45, 12, 59, 53,
        64, 12,-59,-35, 45, 53,-24,-62,
        64,-12,-59, 35, 45,-53,-24, 62,
        64,-35,-24, 62,-45,-12, 59,-53,
        64,-53, 24, 12,-45, 62,-59, 35,
        64,-62, 59,-53, 45,-35, 24,-12 };

    always #10 clk = ~clk;   // 50 MHz

    dct_copro dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic longint cn(int k);
        return (k != 0) ? 64 : 5;
    endfunction

    function automatic int ref_coef(int u, int v);
        longint s, r, k, res;
        r = 0;
        for (int x = 0; x < 8; x++) begin
            s = 0;
            for (int j = 0; j < 8; j++)
                s += (longint'(pix[x*8+j]) * 64 * COS_T[j*8+v]) >>> 6;
            r += (s * COS_T[x*8+u]) >>> 6;
        end
        k   = (((16 * cn(u)) >> 6) * cn(v)) >> 6;
        res = ((r * k) >>> 6) >>> 6;
        return int'(shortint'(res));
    endfunction

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic push_all();
        for (int i = 0; i < 64; i++) wr(2'd3, 8'(pix[i]));
    endtask

    task automatic wait_idle();
        logic [7:0] d;
        int guard = 0;
        do begin
            rd(2'd0, d);
            guard++;
        end while (d == 8'd1 && guard < 6000);
    endtask

    task automatic read_coefs(string tag, int count);
        logic [7:0] hi, lo;
        for (int k = 0; k < count; k++) begin
            rd(2'd2, hi);
            rd(2'd2, lo);
            check(tag, int'(shortint'({hi, lo})), ref_coef(k / 8, k % 8));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int busy_cnt;
        void'($urandom(32'd2024));
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 / R1: idle after reset; command and push offsets read as zero
        rd(2'd0, d); check("R11 status after reset", int'(d), 0);
        rd(2'd1, d); check("R1 command offset read", int'(d), 0);
        rd(2'd3, d); check("R1 push offset read", int'(d), 0);

        // R4: a command value other than 1 does not start
        wr(2'd1, 8'd2);
        rd(2'd0, d); check("R4 non-start command", int'(d), 0);

        // Block A: random pixels, exact busy duration (R8), coefficients (R2 R5 R6 R7)
        for (int i = 0; i < 64; i++) pix[i] = int'($urandom_range(255)) - 128;
        push_all();
        wr(2'd1, 8'd1);
        busy_cnt = 0;
        do begin
            rd(2'd0, d);
            if (d == 8'd1) busy_cnt++;
        end while (d == 8'd1 && busy_cnt < 6000);
        check("R8 busy cycles", busy_cnt, 4672);
        check("R4 status when done", int'(d), 0);
        read_coefs("R2/R5/R6 random block", 64);

        // Block B: writes and start commands while busy are ignored (R10)
        for (int i = 0; i < 64; i++) pix[i] = int'($urandom_range(255)) - 128;
        push_all();
        wr(2'd1, 8'd1);
        rd(2'd0, d); check("R4 status while busy", int'(d), 1);
        wr(2'd3, 8'h55);
        wr(2'd1, 8'd1);
        wr(2'd3, 8'h80);
        wr(2'd1, 8'd1);
        wait_idle();
        read_coefs("R10 block after busy writes", 64);

        // Block C: push index wraps at 64 (R3); partial readout
        for (int i = 0; i < 64; i++) pix[i] = -128;
        push_all();
        wr(2'd3, 8'd127);
        pix[0] = 127;
        wr(2'd1, 8'd1);
        wait_idle();
        read_coefs("R3 wrapped push", 10);
        rd(2'd2, d);

        // Block D: index cleared by completion (R9), pop pointer cleared by start (R7)
        for (int i = 0; i < 5; i++) begin
            wr(2'd3, 8'd127);
            pix[i] = 127;
        end
        wr(2'd1, 8'd1);
        wait_idle();
        read_coefs("R9/R7 partial refill", 64);

        // Block E: checkerboard of extreme values (R5 R6)
        for (int i = 0; i < 64; i++) pix[i] = (((i / 8) + (i % 8)) % 2 == 0) ? 127 : -128;
        push_all();
        wr(2'd1, 8'd1);
        wait_idle();
        read_coefs("R5/R6 checkerboard", 64);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule